// File: doc/BRIEF.md
# SPI Burst Register Reader

This block is the read side of an SPI slave. It watches SCLK, chip select and MOSI through synchronizers clocked by a faster system clock. It collects an 8-bit command and a 16-bit register address. It then streams 32-bit register contents out on MISO, most significant bit first. Data is fetched through a synchronous register-file port: the block presents an address with a read strobe, and the data returns one system clock later.

A window of result registers, starting at 0xE880, supports bursts. When the frame's address lies inside the window, each completed word is followed at once by the next register in the window, for as long as chip select stays low. The next word is prefetched while the current word is shifting out. Past the last register of the window, the address wraps to the window base. An address outside the window returns one word, after which MISO is released. A frame whose command does not request a read is ignored until chip select rises.

Top module: `spi_burst_reader`

## Requirements
- R1: After reset, and whenever chip select has been high for at least six system clocks, `miso_oe_o` and `rd_en_o` are low.
- R2: MOSI is sampled on rising SCLK edges. The first eight bits form the command, most significant bit first. The eighth bit (command bit 0) set to 1 selects a read, whatever the seven bits before it hold.
- R3: If command bit 0 is 0, `miso_oe_o` stays low for the rest of the frame and no register read is issued.
- R4: The 16 bits after the command are the register address, most significant bit first. After the last of them, `rd_en_o` pulses for one system clock with `rd_addr_o` equal to that address.
- R5: MISO is not driven during the 24 header bits. The first data bit is driven after the first falling SCLK edge that follows the last address bit.
- R6: Each 32-bit word leaves MSB first, one bit per falling SCLK edge, with `miso_oe_o` high.
- R7: For a start address in the result window [0xE880, 0xE880+RES_COUNT), the 32 bits of each word are followed directly by the word at the next consecutive address, until chip select rises.
- R8: In a burst, the register after 0xE880+RES_COUNT-1 is 0xE880. No burst read leaves the window.
- R9: For a start address outside the window, exactly one word is sent, and `miso_oe_o` falls after the next falling SCLK edge.
- R10: Raising chip select ends the frame at any point, including mid-header. The output enable drops within a few system clocks, and the next frame starts from a fresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SPI serial clock from the master, idle high |
| cs_n_i | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master (valid when enabled) |
| miso_oe_o | output | 1 | Output enable for the MISO tri-state buffer |
| rd_en_o | output | 1 | Register-file read strobe |
| rd_addr_o | output | 16 | Register-file read address |
| rd_data_i | input | 32 | Register-file data, valid one clock after the strobe |

## Verification
The assertions assume that each SCLK phase lasts long enough for a fetched word to be loaded before the first data bit is due. This takes about four system clocks after a synchronized rising edge. They also assume that the register file answers exactly one clock after the strobe, and that chip select changes only while SCLK is high. The stimulus holds every SCLK phase for six system clocks. It changes pins only on falling system-clock edges, moves chip select only with SCLK high, and models the register file as a one-cycle synchronous read.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  parameter int unsigned SPI_ADDR_W = 16;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_t;

  // Is the address inside the burst window [base, base+count)?
  function automatic logic in_window(input logic [SPI_ADDR_W-1:0] a,
                                     input logic [SPI_ADDR_W-1:0] base,
                                     input int unsigned count);
    int unsigned ai;
    int unsigned bi;
    ai = 32'(a);
    bi = 32'(base);
    return (ai >= bi) && (ai < bi + count);
  endfunction

  // Next burst address, wrapping from the top of the window to its base.
  function automatic logic [SPI_ADDR_W-1:0] step_addr(input logic [SPI_ADDR_W-1:0] a,
                                                      input logic [SPI_ADDR_W-1:0] base,
                                                      input int unsigned count);
    if (32'(a) == 32'(base) + count - 1) return base;
    return a + SPI_ADDR_W'(1);
  endfunction

endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int unsigned       WIDTH   = 3,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/spi_rd_frame.sv
module spi_rd_frame
  import spi_rd_pkg::*;
#(
  parameter int unsigned CMD_W  = 8,
  parameter int unsigned ADDR_W = SPI_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act_i,
  input  logic              rise_i,
  input  logic              mosi_i,
  output phase_t            phase_o,
  output logic              hdr_done_o,
  output logic [ADDR_W-1:0] hdr_addr_o
);
  localparam int unsigned HDR_W = CMD_W + ADDR_W;
  localparam int unsigned CNT_W = $clog2(HDR_W + 1);

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-2:0] sh;
  logic              in_header;

  assign in_header = (phase == PH_CMD) || (phase == PH_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_CMD;
      cnt        <= '0;
      sh         <= '0;
      hdr_done_o <= 1'b0;
      hdr_addr_o <= '0;
    end else begin
      hdr_done_o <= 1'b0;
      if (!cs_act_i) begin
        phase <= PH_CMD;
        cnt   <= '0;
      end else if (rise_i && in_header) begin
        sh  <= {sh[ADDR_W-3:0], mosi_i};
        cnt <= cnt + CNT_W'(1);
        // last command bit is bit 0: read request flag
        if (cnt == CNT_W'(CMD_W - 1))
          phase <= mosi_i ? PH_ADDR : PH_SKIP;
        if (cnt == CNT_W'(HDR_W - 1)) begin
          phase      <= PH_DATA;
          hdr_done_o <= 1'b1;
          hdr_addr_o <= {sh, mosi_i};
        end
      end
    end
  end

  assign phase_o = phase;
endmodule

// File: rtl/spi_rd_fetch.sv
module spi_rd_fetch
  import spi_rd_pkg::*;
#(
  parameter int unsigned       ADDR_W    = SPI_ADDR_W,
  parameter logic [ADDR_W-1:0] RES_BASE  = 16'hE880,
  parameter int unsigned       RES_COUNT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              adv_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              burst_o,
  output logic              ld_o,
  output logic              ld_cur_o
);
  logic              tgt_cur;
  logic              vld1;
  logic              tgt1;
  logic [ADDR_W-1:0] ptr;
  logic              want_next;

  assign want_next = burst_o && ((vld1 && tgt1) || adv_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
      tgt_cur   <= 1'b0;
      vld1      <= 1'b0;
      tgt1      <= 1'b0;
      ptr       <= '0;
      burst_o   <= 1'b0;
    end else begin
      rd_en_o <= 1'b0;
      vld1    <= rd_en_o && cs_act_i;
      tgt1    <= tgt_cur;
      if (!cs_act_i) begin
        burst_o <= 1'b0;
      end else if (start_i) begin
        rd_en_o   <= 1'b1;
        rd_addr_o <= start_addr_i;
        tgt_cur   <= 1'b1;
        ptr       <= start_addr_i;
        burst_o   <= in_window(start_addr_i, RES_BASE, RES_COUNT);
      end else if (want_next) begin
        rd_en_o   <= 1'b1;
        rd_addr_o <= step_addr(ptr, RES_BASE, RES_COUNT);
        tgt_cur   <= 1'b0;
        ptr       <= step_addr(ptr, RES_BASE, RES_COUNT);
      end
    end
  end

  assign ld_o     = vld1;
  assign ld_cur_o = tgt1;
endmodule

// File: rtl/spi_rd_tx.sv
module spi_rd_tx #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act_i,
  input  logic              fall_i,
  input  logic              data_phase_i,
  input  logic              burst_i,
  input  logic              ld_i,
  input  logic              ld_cur_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic              miso_o,
  output logic              oe_o,
  output logic              adv_o,
  output logic              shift_evt_o,
  output logic              swap_o,
  output logic              cur_ok_o,
  output logic              nxt_ok_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] cur;
  logic [DATA_W-1:0] nxt;
  logic [IDX_W-1:0]  idx;
  logic              done;
  logic              last_bit;

  assign shift_evt_o = fall_i && data_phase_i && !done && cs_act_i;
  assign last_bit    = (idx == IDX_W'(DATA_W - 1));
  assign swap_o      = shift_evt_o && last_bit && burst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= '0;
      nxt      <= '0;
      idx      <= '0;
      done     <= 1'b0;
      miso_o   <= 1'b0;
      oe_o     <= 1'b0;
      adv_o    <= 1'b0;
      cur_ok_o <= 1'b0;
      nxt_ok_o <= 1'b0;
    end else begin
      adv_o <= 1'b0;
      if (!cs_act_i) begin
        oe_o     <= 1'b0;
        miso_o   <= 1'b0;
        idx      <= '0;
        done     <= 1'b0;
        cur_ok_o <= 1'b0;
        nxt_ok_o <= 1'b0;
      end else begin
        if (ld_i) begin
          if (ld_cur_i) begin
            cur      <= ld_data_i;
            cur_ok_o <= 1'b1;
          end else begin
            nxt      <= ld_data_i;
            nxt_ok_o <= 1'b1;
          end
        end
        if (shift_evt_o) begin
          miso_o <= cur[IDX_W'(DATA_W - 1) - idx];
          oe_o   <= 1'b1;
          idx    <= idx + IDX_W'(1);
          if (last_bit) begin
            idx <= '0;
            if (burst_i) begin
              cur      <= nxt;
              nxt_ok_o <= 1'b0;
              adv_o    <= 1'b1;
            end else begin
              done <= 1'b1;
            end
          end
        end else if (fall_i && done) begin
          oe_o   <= 1'b0;
          miso_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spi_burst_reader.sv
module spi_burst_reader
  import spi_rd_pkg::*;
#(
  parameter int unsigned           DATA_W      = 32,
  parameter int unsigned           CMD_W       = 8,
  parameter int unsigned           SYNC_STAGES = 2,
  parameter logic [SPI_ADDR_W-1:0] RES_BASE    = 16'hE880,
  parameter int unsigned           RES_COUNT   = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_i,
  input  logic                  cs_n_i,
  input  logic                  mosi_i,
  output logic                  miso_o,
  output logic                  miso_oe_o,
  output logic                  rd_en_o,
  output logic [SPI_ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0]     rd_data_i
);
  localparam int unsigned ADDR_W = SPI_ADDR_W;

  logic [2:0]        pins_s;
  logic              sclk_s, cs_n_s, mosi_s;
  logic              sclk_p;
  logic              sclk_rise, sclk_fall, cs_act;
  phase_t            phase;
  logic              hdr_done;
  logic [ADDR_W-1:0] hdr_addr;
  logic              burst, ld, ld_cur, adv;
  logic              shift_evt, swap, cur_ok, nxt_ok;

  spi_rd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({mosi_i, cs_n_i, sclk_i}),
    .q_o(pins_s)
  );

  assign {mosi_s, cs_n_s, sclk_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_p <= 1'b1;
    else        sclk_p <= sclk_s;

  assign cs_act    = !cs_n_s;
  assign sclk_rise = cs_act && sclk_s && !sclk_p;
  assign sclk_fall = cs_act && !sclk_s && sclk_p;

  spi_rd_frame #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_act_i(cs_act), .rise_i(sclk_rise), .mosi_i(mosi_s),
    .phase_o(phase), .hdr_done_o(hdr_done), .hdr_addr_o(hdr_addr)
  );

  spi_rd_fetch #(.ADDR_W(ADDR_W), .RES_BASE(RES_BASE), .RES_COUNT(RES_COUNT)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .cs_act_i(cs_act), .start_i(hdr_done), .start_addr_i(hdr_addr), .adv_i(adv),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .burst_o(burst),
    .ld_o(ld), .ld_cur_o(ld_cur)
  );

  spi_rd_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .cs_act_i(cs_act), .fall_i(sclk_fall), .data_phase_i(phase == PH_DATA),
    .burst_i(burst), .ld_i(ld), .ld_cur_i(ld_cur), .ld_data_i(rd_data_i),
    .miso_o(miso_o), .oe_o(miso_oe_o), .adv_o(adv),
    .shift_evt_o(shift_evt), .swap_o(swap), .cur_ok_o(cur_ok), .nxt_ok_o(nxt_ok)
  );
endmodule

// File: rtl/spi_burst_reader_chk.sv
module spi_burst_reader_chk
  import spi_rd_pkg::*;
#(
  parameter logic [SPI_ADDR_W-1:0] RES_BASE  = 16'hE880,
  parameter int unsigned           RES_COUNT = 24
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_act,
  input logic                  miso_oe,
  input logic                  rd_en,
  input logic [SPI_ADDR_W-1:0] rd_addr,
  input logic                  burst,
  input phase_t                phase,
  input logic                  shift_evt,
  input logic                  cur_ok,
  input logic                  swap,
  input logic                  nxt_ok
);
  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso_oe);

  assert_idle_no_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !$past(cs_act)) |-> !rd_en);

  assert_reject_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> (!miso_oe && !rd_en));

  assert_read_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  assert_header_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD || phase == PH_ADDR) |-> !miso_oe);

  assert_word_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |-> cur_ok);

  assert_prefetch_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    swap |-> nxt_ok);

  assert_burst_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && burst) |-> in_window(rd_addr, RES_BASE, RES_COUNT));
endmodule

bind spi_burst_reader spi_burst_reader_chk #(.RES_BASE(RES_BASE), .RES_COUNT(RES_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .miso_oe(miso_oe_o),
  .rd_en(rd_en_o), .rd_addr(rd_addr_o), .burst(burst), .phase(phase),
  .shift_evt(shift_evt), .cur_ok(cur_ok), .swap(swap), .nxt_ok(nxt_ok)
);

// File: tb/spi_burst_reader_bench.sv
module spi_burst_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HP         = 6;
  localparam logic [15:0] BASE = 16'hE880;
  localparam int COUNT      = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic        miso_o, miso_oe_o, rd_en_o;
  logic [15:0] rd_addr_o;
  logic [31:0] rd_data = '0;

  int vectors = 0;
  int errors  = 0;
  int hi_cnt  = 0;
  bit finished = 0;
  logic [15:0] rdq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_burst_reader #(.RES_BASE(BASE), .RES_COUNT(COUNT)) u_spi_burst_reader (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .rd_en_o(rd_en_o),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data)
  );

  function automatic logic [31:0] reg_val(input logic [15:0] a);
    return {a ^ 16'h5A3C, ~a} + {16'h0, a[7:0], 8'h11};
  endfunction

  function automatic logic [15:0] next_reg(input logic [15:0] a);
    return (a == BASE + 16'(COUNT - 1)) ? BASE : a + 16'd1;
  endfunction

  // one-cycle synchronous register file
  always @(posedge clk) if (rd_en_o) rd_data <= reg_val(rd_addr_o);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock idle model: long-idle chip select means a quiet block (R1)
  always @(negedge clk) begin
    if (rd_en_o) rdq.push_back(rd_addr_o);
    if (rst_n && cs_n) hi_cnt++; else hi_cnt = 0;
    if (hi_cnt >= 6)
      chk(!miso_oe_o && !rd_en_o, "R1 idle quiet", {miso_oe_o, rd_en_o}, 2'b00);
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] cmd, input logic [15:0] addr, input int nwords);
    logic [23:0] hdr;
    logic [15:0] a;
    logic [31:0] w;
    bit in_win;
    bit exp_oe;
    hdr = {cmd, addr};
    in_win = (addr >= BASE) && (int'(addr) < int'(BASE) + COUNT);
    rdq.delete();
    cs_n = 1'b0;
    wait_n(HP);
    for (int i = 23; i >= 0; i--) begin
      sclk = 1'b0; mosi = hdr[i];
      wait_n(HP);
      chk(!miso_oe_o, "R5 header quiet", miso_oe_o, 0);
      sclk = 1'b1;
      wait_n(HP);
    end
    a = addr;
    for (int n = 0; n < nwords; n++) begin
      w = reg_val(a);
      exp_oe = cmd[0] && (in_win || n == 0);
      for (int k = 31; k >= 0; k--) begin
        sclk = 1'b0;
        wait_n(HP);
        if (!cmd[0])
          chk(!miso_oe_o, "R3 rejected frame silent", miso_oe_o, 0);
        else if (!exp_oe)
          chk(!miso_oe_o, "R9 release after single word", miso_oe_o, 0);
        else if (n == 0)
          chk(miso_oe_o && miso_o == w[k], "R6 word bit MSB first",
              {miso_oe_o, miso_o}, {1'b1, w[k]});
        else
          chk(miso_oe_o && miso_o == w[k], "R7/R8 burst word bit",
              {miso_oe_o, miso_o}, {1'b1, w[k]});
        sclk = 1'b1;
        wait_n(HP);
      end
      a = next_reg(a);
    end
    cs_n = 1'b1;
    wait_n(4);
    chk(!miso_oe_o, "R10 release on chip select", miso_oe_o, 0);
    if (!cmd[0])
      chk(rdq.size() == 0, "R3 no read issued", rdq.size(), 0);
    else
      chk(rdq.size() > 0 && rdq[0] == addr, "R4 first read address",
          rdq.size() > 0 ? rdq[0] : 16'hxxxx, addr);
    wait_n(8);
  endtask

  task automatic abort_frame(input int nbits);
    cs_n = 1'b0;
    wait_n(HP);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0; mosi = 1'b1;
      wait_n(HP);
      sclk = 1'b1;
      wait_n(HP);
    end
    cs_n = 1'b1;
    wait_n(4);
    chk(!miso_oe_o, "R10 aborted header quiet", miso_oe_o, 0);
    wait_n(8);
  endtask

  initial begin
    wait_n(3);
    chk(!miso_oe_o && !rd_en_o, "R1 reset state", {miso_oe_o, rd_en_o}, 0);
    rst_n = 1'b1;
    wait_n(10);
    frame(8'h01, 16'h0123, 2);               // R9 single outside window, R4, R6
    frame(8'hFF, 16'hA5C3, 1);               // R2 upper command bits ignored
    frame(8'h8B, 16'h0000, 1);               // R2 another command pattern
    frame(8'h01, BASE, 3);                   // R7 burst from window base
    frame(8'h71, BASE + 16'(COUNT - 2), 4);  // R8 wrap at the window top
    frame(8'h70, BASE + 16'd3, 2);           // R3 bit 0 clear: rejected
    abort_frame(10);                         // R10 abort mid-header
    frame(8'h01, BASE + 16'(COUNT - 1), 1);  // R10 fresh frame, last window reg
    frame(8'h01, BASE - 16'd1, 2);           // R9 just below the window
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule